// File: doc/BRIEF.md
# Peripheral Low-Power Handshake Responder

This block is the peripheral end of a four-phase low-power clock handshake. A system clock controller pulls `sys_req` low to ask whether the peripheral's clocks may be stopped. The responder brings that request into its own clock domain and makes one decision. If any bit of the `busy` vector is set, it refuses: `clk_need` stays high and `sys_ack` drops. If all busy bits are clear, it asks the peripheral to power down through `pd_req`. It waits, with no time limit, for `pd_done`, and then lowers `clk_need` and `sys_ack` on the same clock edge.

When the controller raises `sys_req` again, the responder raises `sys_ack` to close the handshake and restores `clk_need`. While it is powered down, the peripheral can assert `wake` to ask for its clocks back. The responder then raises `clk_need` and holds it high until the handshake ends. The controller always sees a settled `clk_need` in the cycle where `sys_ack` falls, so it can read the decision from that one sample.

Top module: `lp_responder`

## Requirements
- R1: While `rst_n` is low and after reset is released, `sys_ack` is 1, `clk_need` is 1 and `pd_req` is 0.
- R2: When `sys_req` falls and any `busy` bit is 1 at the cycle the request is recognised (SYNC_STAGES+1 clock edges after the fall), the request is denied. `sys_ack` goes to 0 on that edge, `clk_need` stays 1 and `pd_req` stays 0.
- R3: When all `busy` bits are 0 at that cycle, the request is accepted. `pd_req` rises on that edge. `sys_ack` and `clk_need` stay 1 for as long as `pd_done` stays 0, with no timeout.
- R4: On the first clock edge where `pd_done` is 1 while `pd_req` is 1, `sys_ack` and `clk_need` both fall to 0 and `pd_req` falls to 0.
- R5: `clk_need` never falls except on the same edge as a fall of `sys_ack`.
- R6: After `sys_req` returns to 1 while `sys_ack` is 0, `sys_ack` rises SYNC_STAGES+1 clock edges later, with `clk_need` 1 on that same edge.
- R7: In the accepted low-power state, `wake` at 1 raises `clk_need` on the next edge while `sys_ack` stays 0. `clk_need` then stays 1 even if `wake` drops, until `sys_ack` rises.
- R8: In the low-power state, `busy` has no effect on `clk_need`. While `pd_req` is 0, `pd_done` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_req | input | 1 | Controller request, low asks for low power (asynchronous) |
| busy | input | BUSY_W | Busy flags from the peripheral, any bit set forces a deny |
| wake | input | 1 | Peripheral asks for clocks while in low power |
| pd_done | input | 1 | Peripheral has finished its power-down work |
| pd_req | output | 1 | Asks the peripheral to perform its power-down work |
| sys_ack | output | 1 | Acknowledge to the controller, low while the request is held |
| clk_need | output | 1 | High when the peripheral needs its clocks |

## Verification
A change on `sys_req` passes through SYNC_STAGES synchroniser flops and one state register. Its effect on `sys_ack` is therefore due on edge SYNC_STAGES+1 after the change. The bench checks the unchanged value one edge earlier and the new value on that edge. `pd_done` and `wake` are in the local clock domain and act on the first edge after they are driven. Every input is driven on a falling clock edge, and every output is sampled on the falling edge that follows the rising edge where the result is due. The sweep covers every `busy` pattern, with and without a wake, and several power-down latencies.

// File: rtl/lp_resp_pkg.sv
// Package: shared types for the low-power handshake responder.
// Assumes nothing beyond being compiled before the modules that import it.
package lp_resp_pkg;

    // Handshake states of the responder
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,   // clocks on, no request pending
        ST_PWRDN  = 3'd1,   // accepted, waiting for power-down work
        ST_DENIED = 3'd2,   // refused, waiting for the request to drop
        ST_SLEEP  = 3'd3,   // accepted, clocks may be stopped
        ST_WAKING = 3'd4    // low power, clocks requested back
    } lp_state_t;

endpackage

// File: rtl/lp_req_sync.sv
// Module: lp_req_sync
// Brings the asynchronous controller request into the local clock domain
// through a chain of STAGES flops. It assumes the request is level-held
// long enough to be seen, which the four-phase protocol guarantees.
// Reset value is 1 (no request).
module lp_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first flop samples the raw asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // each later flop resolves the previous stage
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lp_resp_fsm.sv
// Module: lp_resp_fsm
// Decides between accepting and denying a low-power request and tracks
// the handshake phase. It exposes the next state so that the output
// registers can update on the same edge as the state register.
// Assumes req_low is synchronous, and that the controller holds the request
// low until the acknowledge falls.
module lp_resp_fsm
    import lp_resp_pkg::*;
#(
    parameter int BUSY_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_low,
    input  logic [BUSY_W-1:0] busy,
    input  logic              wake,
    input  logic              pd_done,
    output lp_state_t         state_nxt
);

    lp_state_t state_q;
    logic      any_busy;

    // reduce the busy vector to a single deny condition
    assign any_busy = |busy;

    // next-state decision for the four-phase handshake
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_low) state_nxt = any_busy ? ST_DENIED : ST_PWRDN;
            end
            ST_PWRDN: begin
                if (pd_done) state_nxt = ST_SLEEP;
            end
            ST_DENIED: begin
                if (!req_low) state_nxt = ST_RUN;
            end
            ST_SLEEP: begin
                if (!req_low)  state_nxt = ST_RUN;
                else if (wake) state_nxt = ST_WAKING;
            end
            ST_WAKING: begin
                if (!req_low) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // hold the current handshake phase
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nxt;
    end

endmodule

// File: rtl/lp_resp_out.sv
// Module: lp_resp_out
// Registers the handshake outputs from the next state so that every output
// comes straight from a flop, and so that clk_need and sys_ack change on the
// same edge. Assumes the next state is valid in every cycle after reset.
module lp_resp_out
    import lp_resp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lp_state_t state_nxt,
    output logic      ack_q,
    output logic      need_q,
    output logic      pd_q
);

    logic ack_d, need_d, pd_d;

    // decode the output levels of the coming state
    always_comb begin
        ack_d  = (state_nxt == ST_RUN) || (state_nxt == ST_PWRDN);
        need_d = (state_nxt != ST_SLEEP);
        pd_d   = (state_nxt == ST_PWRDN);
    end

    // output flops, all driven from the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b1;
            need_q <= 1'b1;
            pd_q   <= 1'b0;
        end else begin
            ack_q  <= ack_d;
            need_q <= need_d;
            pd_q   <= pd_d;
        end
    end

endmodule

// File: rtl/lp_responder.sv
// Module: lp_responder (top)
// Peripheral-side agent of the low-power clock handshake. It synchronises
// the controller request, denies when busy, and otherwise runs the
// power-down step before it accepts. It drives the acknowledge and the
// clock-need flag. Assumes busy, wake and pd_done are in the clk domain.
module lp_responder #(
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_req,
    input  logic [BUSY_W-1:0] busy,
    input  logic              wake,
    input  logic              pd_done,
    output logic              pd_req,
    output logic              sys_ack,
    output logic              clk_need
);

    import lp_resp_pkg::*;

    logic      req_s;
    logic      req_low;
    lp_state_t state_nxt;

    lp_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sys_req),
        .sync_out (req_s)
    );

    assign req_low = !req_s;

    lp_resp_fsm #(.BUSY_W(BUSY_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_low   (req_low),
        .busy      (busy),
        .wake      (wake),
        .pd_done   (pd_done),
        .state_nxt (state_nxt)
    );

    lp_resp_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .ack_q     (sys_ack),
        .need_q    (clk_need),
        .pd_q      (pd_req)
    );

endmodule

// File: rtl/lp_responder_chk.sv
// Module: lp_responder_chk
// Port-level protocol checks for lp_responder, attached with bind.
module lp_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic pd_done,
    input logic pd_req,
    input logic sys_ack,
    input logic clk_need
);

    // R2: a deny is never preceded by a power-down request
    a_r2_deny_no_pd: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_ack) && clk_need) |-> !$past(pd_req));

    // R3: acknowledge stays high while power-down is pending
    a_r3_pd_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> sys_ack);

    // R4: an accept follows a completed power-down request
    a_r4_accept_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_ack) && !clk_need) |-> ($past(pd_req) && $past(pd_done)));

    // R5: clk_need only drops together with the acknowledge
    a_r5_need_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_need) |-> $fell(sys_ack));

    // R6: closing the handshake restores clk_need
    a_r6_exit_need_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_ack) |-> clk_need);

    // R7: once raised during low power, clk_need holds until ack rises
    a_r7_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_ack && $past(!sys_ack) && $past(clk_need)) |-> clk_need);

endmodule

bind lp_responder lp_responder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_done  (pd_done),
    .pd_req   (pd_req),
    .sys_ack  (sys_ack),
    .clk_need (clk_need)
);

// File: tb/sim_lp_responder.sv
module sim_lp_responder;

    localparam int SYNC = 2;
    localparam int BW   = 2;
    localparam int LAT  = SYNC + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sys_req = 1'b1;
    logic [BW-1:0] busy = '0;
    logic          wake = 1'b0;
    logic          pd_done = 1'b0;
    logic          pd_req, sys_ack, clk_need;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lp_responder #(.SYNC_STAGES(SYNC), .BUSY_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_req(sys_req), .busy(busy),
        .wake(wake), .pd_done(pd_done), .pd_req(pd_req),
        .sys_ack(sys_ack), .clk_need(clk_need)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {ack,need,pd} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] outs();
        return {sys_ack, clk_need, pd_req};
    endfunction

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic handshake(input logic [BW-1:0] bv, input bit wk, input int pd_lat);
        bit deny;
        deny = (bv != '0);
        busy = bv;
        sys_req = 1'b0;
        edges(LAT - 1);
        chk("R2 latency", outs(), 3'b110);
        edges(1);
        if (deny) begin
            chk("R2 deny", outs(), 3'b010);
        end else begin
            chk("R3 accept start", outs(), 3'b111);
            for (int i = 0; i < pd_lat; i++) begin
                edges(1);
                chk("R3 wait no timeout", outs(), 3'b111);
            end
            pd_done = 1'b1;
            edges(1);
            pd_done = 1'b0;
            chk("R4 accept", outs(), 3'b000);
            busy = '1;
            edges(2);
            chk("R8 busy ignored in low power", outs(), 3'b000);
            busy = bv;
            if (wk) begin
                wake = 1'b1;
                edges(1);
                chk("R7 wake raises need", outs(), 3'b010);
                wake = 1'b0;
                edges(2);
                chk("R7 need held", outs(), 3'b010);
            end
        end
        sys_req = 1'b1;
        edges(LAT - 1);
        chk("R6 ack not yet", outs(), {1'b0, (deny || wk), 1'b0});
        edges(1);
        chk("R6 exit", outs(), 3'b110);
        busy = '0;
        edges(2);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        edges(1);
        chk("R1 in reset", outs(), 3'b110);
        edges(3);
        rst_n = 1'b1;
        edges(2);
        chk("R1 after reset", outs(), 3'b110);
        pd_done = 1'b1;
        edges(1);
        pd_done = 1'b0;
        chk("R8 pd_done ignored in run", outs(), 3'b110);
        wake = 1'b1;
        edges(1);
        wake = 1'b0;
        chk("R8 wake ignored in run", outs(), 3'b110);
        for (int b = 0; b < (1 << BW); b++) begin
            for (int w = 0; w < 2; w++) begin
                for (int p = 0; p < 4; p += 3) begin
                    handshake(b[BW-1:0], w[0], p);
                end
            end
        end
        handshake('0, 1'b1, 9);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule